// File: doc/BRIEF.md
# Channel Status Buffer Sequencer

This block holds one full channel-status block for a two-channel digital audio transmitter. The block has 24 bytes. Each byte goes out one bit per frame, where a frame is one left/right sample pair. The same bit goes to both subframes of that frame. A host port can read or write any of the 24 byte locations (host addresses 0x08 to 0x1F) at any time. The transmitter side walks the buffer in a fixed cyclic order and never clears it, so the same block repeats until the host changes it.

The transmitter pulses `frame_tick` once per frame. Every eighth tick fetches the next byte into a shift register, and the other ticks shift that register by one place. A half-block flag marks which half of the block is going out. When enabled, every transition of that flag gives a one-cycle interrupt pulse. A separate strobe tells the user-data path to re-read its buffer when a particular byte is fetched.

The bit stream has no back-pressure. The consumer pulls one bit per `frame_tick`, and the block must always have a bit ready, so there is no valid/ready pair. Host and status pins are plain level or pulse signals.

Top module: `cs_block_seq`

## Requirements
- R1: While reset is held and until the first `frame_tick`, `cs_bit`, `irq` and `ubuf_reread` are 0, `flag_half` is 1 and `host_rdata` is 0.
- R2: A host write with `host_en`=1, `host_we`=1 to an address from 0x08 to 0x1F stores the byte at buffer index (address − 0x08). A read with `host_en`=1, `host_we`=0 returns that byte on `host_rdata` one clock later. Writes to addresses below 0x08 are ignored, and reads of them return 0.
- R3: The first `frame_tick` after reset fetches index 0. Starting in the cycle after each tick and lasting until the next tick, `cs_bit` carries bit n of the current byte, where n counts the ticks since that byte's fetch (n = 0 is the fetch tick). Bits go out LSB first.
- R4: Each byte serves exactly eight frames. Indices are fetched in the order 0, 1, …, 23 and then wrap to 0, so one block is 192 frames. Fetching does not alter the buffer, so a later pass sends the same data.
- R5: `flag_half` falls in the cycle after the tick that fetches index 0 and rises in the cycle after the tick that fetches index 16. At no other time does it change.
- R6: `irq` is a one-cycle pulse in the cycle after a tick that changes `flag_half`. It only fires if `irq_en` was 1 at that tick. At all other times `irq` is 0.
- R7: `ubuf_reread` is a one-cycle pulse in the cycle after the tick that fetches index 2 (host address 0x0A). At all other times it is 0.
- R8: If a host write and a fetch address the same location in the same cycle, the transmitter sends the old byte. The new byte is stored and goes out on the next pass.
- R9: Host reads and writes issued between ticks do not disturb the bit sequence, the flag or the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Host byte address; the buffer occupies 0x08 to 0x1F |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle after the read |
| frame_tick | input | 1 | One pulse per transmitted frame |
| irq_en | input | 1 | Interrupt enable for half-block flag transitions |
| cs_bit | output | 1 | Channel-status bit for the current frame (both subframes) |
| flag_half | output | 1 | Low during the first two-thirds of the block, high from index 16 |
| irq | output | 1 | One-cycle interrupt pulse |
| ubuf_reread | output | 1 | One-cycle strobe asking the user-data buffer to re-read |

## Verification
A host write and a transmitter fetch can land on the same buffer location in the same clock cycle. The bench provokes this by driving a write to host address 0x0D together with the tick that fetches index 5. Its reference model captures the fetched byte before it applies the write. The scoreboard then expects the old bits for those eight frames and the new bits one block later, and a read-back confirms that the write was stored. The interrupt pulse and the re-read strobe are also checked around the same fetch boundaries, once with `irq_en` set and once with it cleared.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
  localparam int unsigned CS_BYTES  = 24;
  localparam int unsigned CS_BASE   = 8;
  localparam int unsigned CS_HOSTAW = 5;
  localparam int unsigned CS_DW     = 8;

  typedef enum logic [1:0] {
    FLAG_HOLD = 2'd0,
    FLAG_CLR  = 2'd1,
    FLAG_SET  = 2'd2
  } flag_cmd_t;
endpackage

// File: rtl/cs_regfile.sv
module cs_regfile #(
  parameter int unsigned NB   = 24,
  parameter int unsigned BASE = 8,
  parameter int unsigned AW   = 5,
  parameter int unsigned DW   = 8,
  localparam int unsigned IW  = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_en,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [IW-1:0] fetch_idx,
  output logic [DW-1:0] fetch_byte
);
  localparam int unsigned LAST = BASE + NB - 1;

  logic [DW-1:0] mem [NB];
  logic          hit;
  logic [AW-1:0] off;
  logic [IW-1:0] hidx;

  assign hit  = (int'(host_addr) >= BASE) && (int'(host_addr) <= LAST);
  assign off  = host_addr - AW'(BASE);
  assign hidx = off[IW-1:0];

  // transmitter read port sees the pre-write contents on a same-cycle hit
  assign fetch_byte = mem[fetch_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= '0;
      host_rdata <= '0;
    end else if (host_en) begin
      if (host_we) begin
        if (hit) mem[hidx] <= host_wdata;
      end else begin
        host_rdata <= hit ? mem[hidx] : '0;
      end
    end
  end
endmodule

// File: rtl/cs_fetch_seq.sv
module cs_fetch_seq #(
  parameter int unsigned NB        = 24,
  parameter int unsigned DW        = 8,
  parameter int unsigned LSB_FIRST = 1,
  localparam int unsigned IW       = $clog2(NB),
  localparam int unsigned BW       = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  logic [DW-1:0] fetch_byte,
  output logic [IW-1:0] fetch_idx,
  output logic          fetch_now,
  output logic          cs_bit
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  logic [IW-1:0] ptr;
  logic [BW-1:0] bit_cnt;
  logic [DW-1:0] shreg;
  logic [DW-1:0] shifted;

  assign fetch_idx = (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
  assign fetch_now = frame_tick && (bit_cnt == LAST_BIT);

  generate
    if (LSB_FIRST != 0) begin : g_lsb
      assign cs_bit  = shreg[0];
      assign shifted = {1'b0, shreg[DW-1:1]};
    end else begin : g_msb
      assign cs_bit  = shreg[DW-1];
      assign shifted = {shreg[DW-2:0], 1'b0};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= LAST_IDX;
      bit_cnt <= LAST_BIT;
      shreg   <= '0;
    end else if (frame_tick) begin
      if (fetch_now) begin
        shreg   <= fetch_byte;
        ptr     <= fetch_idx;
        bit_cnt <= '0;
      end else begin
        shreg   <= shifted;
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cs_flag_gen.sv
module cs_flag_gen
  import cs_seq_pkg::*;
#(
  parameter int unsigned NB         = 24,
  parameter int unsigned START_IDX  = 0,
  parameter int unsigned HALF_IDX   = 16,
  parameter int unsigned REREAD_IDX = 2,
  localparam int unsigned IW        = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_now,
  input  logic [IW-1:0] fetch_idx,
  input  logic          irq_en,
  output logic          flag_half,
  output logic          irq,
  output logic          reread
);
  flag_cmd_t cmd;
  logic      flag_nxt;

  always_comb begin
    cmd = FLAG_HOLD;
    if (fetch_now && fetch_idx == IW'(START_IDX))     cmd = FLAG_CLR;
    else if (fetch_now && fetch_idx == IW'(HALF_IDX)) cmd = FLAG_SET;
  end

  always_comb begin
    case (cmd)
      FLAG_CLR: flag_nxt = 1'b0;
      FLAG_SET: flag_nxt = 1'b1;
      default:  flag_nxt = flag_half;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_half <= 1'b1;
      irq       <= 1'b0;
      reread    <= 1'b0;
    end else begin
      flag_half <= flag_nxt;
      irq       <= irq_en && (flag_nxt != flag_half);
      reread    <= fetch_now && (fetch_idx == IW'(REREAD_IDX));
    end
  end
endmodule

// File: rtl/cs_block_seq.sv
module cs_block_seq
  import cs_seq_pkg::*;
#(
  parameter int unsigned NB         = CS_BYTES,
  parameter int unsigned BASE       = CS_BASE,
  parameter int unsigned AW         = CS_HOSTAW,
  parameter int unsigned DW         = CS_DW,
  parameter int unsigned HALF_IDX   = 16,
  parameter int unsigned REREAD_IDX = 2,
  parameter int unsigned LSB_FIRST  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_en,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          frame_tick,
  input  logic          irq_en,
  output logic          cs_bit,
  output logic          flag_half,
  output logic          irq,
  output logic          ubuf_reread
);
  localparam int unsigned IW = $clog2(NB);

  logic [IW-1:0] fetch_idx;
  logic [DW-1:0] fetch_byte;
  logic          fetch_now;

  cs_regfile #(.NB(NB), .BASE(BASE), .AW(AW), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .fetch_idx(fetch_idx), .fetch_byte(fetch_byte)
  );

  cs_fetch_seq #(.NB(NB), .DW(DW), .LSB_FIRST(LSB_FIRST)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .fetch_byte(fetch_byte), .fetch_idx(fetch_idx),
    .fetch_now(fetch_now), .cs_bit(cs_bit)
  );

  cs_flag_gen #(.NB(NB), .START_IDX(0), .HALF_IDX(HALF_IDX),
                .REREAD_IDX(REREAD_IDX)) u_flag (
    .clk(clk), .rst_n(rst_n), .fetch_now(fetch_now),
    .fetch_idx(fetch_idx), .irq_en(irq_en),
    .flag_half(flag_half), .irq(irq), .reread(ubuf_reread)
  );
endmodule

// File: rtl/cs_seq_chk.sv
module cs_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_tick,
  input logic cs_bit,
  input logic flag_half,
  input logic irq,
  input logic ubuf_reread
);
  // R6: pulse lasts one cycle
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R6: pulse only accompanies a flag transition
  assert_irq_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_half != $past(flag_half)));
  // R5: flag only moves after a tick
  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> $stable(flag_half));
  // R3: bit held between ticks
  assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> $stable(cs_bit));
  // R7: strobe follows a tick and is one cycle wide
  assert_reread_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ubuf_reread |-> $past(frame_tick));
  assert_reread_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ubuf_reread |=> !ubuf_reread);
endmodule

bind cs_block_seq cs_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .cs_bit(cs_bit),
  .flag_half(flag_half), .irq(irq), .ubuf_reread(ubuf_reread)
);

// File: tb/cs_block_seq_tb.sv
module cs_block_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_en = 1'b0, host_we = 1'b0;
  logic [4:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       frame_tick = 1'b0, irq_en = 1'b0;
  logic       cs_bit, flag_half, irq, ubuf_reread;

  cs_block_seq u_dut (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .frame_tick(frame_tick), .irq_en(irq_en), .cs_bit(cs_bit),
    .flag_half(flag_half), .irq(irq), .ubuf_reread(ubuf_reread)
  );

  always #5 clk = ~clk;

  typedef struct { bit b; bit fl; bit iq; bit rr; bit coll; } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit mon_on = 0, done = 0;
  logic tick_d = 1'b0;

  logic [7:0] exp_mem [24];
  int  m_ptr = 23, m_bit = 7;
  bit  m_flag = 1, m_coll = 0;
  logic [7:0] m_byte = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 53 + 17) & 255);
  endfunction

  always @(posedge clk) tick_d <= frame_tick;

  // monitor: compares one scoreboard entry per tick
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (tick_d) begin
        if (q.size() == 0) check(0, "R4 queue empty", 0, 1);
        else begin
          exp_t e;
          e = q.pop_front();
          check(cs_bit == e.b, e.coll ? "R8 bit" : "R3/R4 bit", int'(cs_bit), int'(e.b));
          check(flag_half == e.fl, "R5 flag", int'(flag_half), int'(e.fl));
          check(irq == e.iq, "R6 irq", int'(irq), int'(e.iq));
          check(ubuf_reread == e.rr, "R7 reread", int'(ubuf_reread), int'(e.rr));
        end
      end else begin
        check(irq == 1'b0, "R6 idle irq", int'(irq), 0);
        check(ubuf_reread == 1'b0, "R7 idle reread", int'(ubuf_reread), 0);
      end
    end
  end

  task automatic frame(input bit do_wr, input logic [4:0] wa, input logic [7:0] wd);
    exp_t e;
    bit nf;
    @(negedge clk);
    frame_tick = 1'b1;
    if (do_wr) begin host_en = 1'b1; host_we = 1'b1; host_addr = wa; host_wdata = wd; end
    e.rr = 0; e.iq = 0;
    if (m_bit == 7) begin
      m_ptr  = (m_ptr + 1) % 24;
      m_byte = exp_mem[m_ptr];
      m_bit  = 0;
      m_coll = do_wr && (int'(wa) - 8 == m_ptr);
      e.rr   = (m_ptr == 2);
      nf = m_flag;
      if (m_ptr == 0) nf = 0;
      else if (m_ptr == 16) nf = 1;
      e.iq = irq_en && (nf != m_flag);
      m_flag = nf;
    end else m_bit++;
    e.b = m_byte[m_bit]; e.fl = m_flag; e.coll = m_coll;
    q.push_back(e);
    if (do_wr && int'(wa) >= 8) exp_mem[int'(wa) - 8] = wd;
    @(negedge clk);
    frame_tick = 1'b0; host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) frame(0, 5'd0, 8'd0);
  endtask

  task automatic host_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_read(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_en = 1'b0;
    check(host_rdata == exp, tag, int'(host_rdata), int'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 24; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    check(cs_bit == 0 && irq == 0 && ubuf_reread == 0, "R1 outs in reset", int'(cs_bit | irq | ubuf_reread), 0);
    check(flag_half == 1, "R1 flag in reset", int'(flag_half), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(host_rdata == 0, "R1 rdata", int'(host_rdata), 0);
    check(flag_half == 1 && cs_bit == 0, "R1 after release", int'(flag_half), 1);

    for (int i = 0; i < 24; i++) begin
      host_write(5'(8 + i), pat(i));
      exp_mem[i] = pat(i);
    end
    host_write(5'h03, 8'hAA);
    host_read(5'h03, 8'h00, "R2 unmapped read");
    host_read(5'h0F, pat(7), "R2 readback 0x0F");
    host_read(5'h1F, pat(23), "R2 readback 0x1F");
    host_read(5'h08, pat(0), "R2 readback 0x08");

    mon_on = 1;
    irq_en = 1'b1;
    frames(50);
    host_read(5'h12, pat(10), "R9 read mid-stream");
    frames(142);

    irq_en = 1'b0;
    frames(100);
    host_write(5'h03, 8'h55);
    frames(92);

    irq_en = 1'b1;
    frames(40);
    frame(1, 5'h0D, ~pat(5));
    frames(7);
    host_read(5'h0D, ~pat(5), "R8 new byte stored");
    frames(192);

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R4 queue drained", q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule